// File: doc/BRIEF.md
# SIMD Narrowing and Widening Shifter

This block is a vector shift unit for immediate-shift instructions that change lane width. In narrowing mode it views a 128-bit source as lanes of double width. It shifts each lane right by an immediate amount, with optional round-to-nearest, and keeps the low half of every lane. The packed 64-bit product is placed in either the lower or the upper half of the destination. In widening mode it takes one 64-bit half of the source, sign- or zero-extends each lane to double width, and shifts each extended lane left. The result fills all 128 bits.

The lane width and the shift amount both come from a seven-bit immediate split into a 4-bit high field and a 3-bit low field. A half-select bit picks which 64-bit half is read when widening, or written when narrowing. Two flags report an all-zero high field and a reserved high field. Every operation takes one clock: the inputs are sampled when `in_valid` is high, and the result appears on the registered outputs one cycle later.

Top module: `nws_shift_unit`

## Requirements
- R1: The outputs are registered. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` and both flags update only on accepted operations and hold otherwise. Synchronous reset clears `out_valid`, `result` and both flags.
- R2: A high field of 0000 sets `err_decode`, clears `err_reserved`, and forces `result` to zero.
- R3: A high field with bit 3 set sets `err_reserved`, clears `err_decode`, and forces `result` to zero in both modes.
- R4: The narrow lane width N is 8 for a high field of 0001, 16 for 001x, and 32 for 01xx. The wide lane width is 2N.
- R5: A narrowing shift amount is 2N minus the seven-bit value {high, low}. The shift is logical, to the right, on each 2N-bit lane. Narrow lane i is the low N bits of shifted wide lane i, packed from bit 0 upward.
- R6: With `round_en` high, a narrowing operation adds 2^(shift-1) to each wide lane before shifting. The sum keeps its carry, so it does not wrap.
- R7: A narrowing operation with `half_sel`=0 writes the packed lanes to `result[63:0]` and zeros `result[127:64]`.
- R8: A narrowing operation with `half_sel`=1 writes the packed lanes to `result[127:64]` and copies `dst_keep` into `result[63:0]`.
- R9: A widening operation reads `src[63:0]` when `half_sel`=0 and `src[127:64]` when `half_sel`=1. It shifts each extended lane left by {high, low} minus N, a range of 0 to N-1, inside its 2N-bit lane.
- R10: A widening operation sign-extends each lane when `is_signed`=1 and zero-extends it when `is_signed`=0.
- R11: In narrowing mode, `is_signed` has no effect. In widening mode, `round_en` and `dst_keep` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operation this cycle |
| src | input | 128 | Source vector |
| dst_keep | input | 64 | Old destination low half, kept by an upper-half narrowing write |
| half_sel | input | 1 | Half select: 0 lower, 1 upper |
| imm_hi | input | 4 | Immediate high field (lane width select) |
| imm_lo | input | 3 | Immediate low field |
| op_widen | input | 1 | 1 widening, 0 narrowing |
| is_signed | input | 1 | Sign-extend when widening |
| round_en | input | 1 | Round when narrowing |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Shifted vector |
| err_decode | output | 1 | High field was zero |
| err_reserved | output | 1 | High field had its top bit set |

## Verification
The bench builds the unit with its default 128-bit vector width. At that width all three narrow lane widths (8, 16, 32) occur, with 8, 4 and 2 lanes per half. The largest case is 32-bit lanes with a shift of 32. Random immediates reach every shift amount for each width in both modes. Directed cases cover the rounding carry out of a full wide lane, a shift of zero when widening, and negative lanes under sign extension.

// File: rtl/nws_pkg.sv
package nws_pkg;
  localparam int IMMH_W = 4;
  localparam int IMMB_W = 3;
  localparam int IMM_W  = IMMH_W + IMMB_W;
  localparam int SH_W   = 6;
  localparam int NUM_LW = 3;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2
  } lane_w_e;

  typedef struct packed {
    logic            dec_err;
    logic            rsv_err;
    lane_w_e         lw;
    logic [SH_W-1:0] sh_nar;
    logic [SH_W-1:0] sh_wid;
  } dec_t;
endpackage

// File: rtl/nws_decode.sv
module nws_decode
  import nws_pkg::*;
(
  input  logic [IMMH_W-1:0] imm_hi,
  input  logic [IMMB_W-1:0] imm_lo,
  output dec_t              dcd
);
  logic [IMM_W-1:0] imm7;
  logic [IMM_W-1:0] nw;

  always_comb begin
    imm7        = {imm_hi, imm_lo};
    dcd.dec_err = (imm_hi == '0);
    dcd.rsv_err = imm_hi[IMMH_W-1];
    casez (imm_hi[2:0])
      3'b1??:  dcd.lw = LW_32;
      3'b01?:  dcd.lw = LW_16;
      default: dcd.lw = LW_8;
    endcase
    nw         = IMM_W'(8) << dcd.lw;
    dcd.sh_nar = SH_W'((nw << 1) - imm7);
    dcd.sh_wid = SH_W'(imm7 - nw);
  end
endmodule

// File: rtl/nws_narrow.sv
module nws_narrow
  import nws_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]   src,
  input  lane_w_e            lw,
  input  logic [SH_W-1:0]    sh,
  input  logic               rnd,
  output logic [VEC_W/2-1:0] nar
);
  localparam int HALF_W = VEC_W / 2;

  logic [NUM_LW-1:0][HALF_W-1:0] cand;

  for (genvar k = 0; k < NUM_LW; k++) begin : g_w
    localparam int NE    = 8 << k;
    localparam int WE    = 2 * NE;
    localparam int LANES = HALF_W / NE;
    for (genvar l = 0; l < LANES; l++) begin : g_l
      logic [WE:0] wide;
      logic [WE:0] addend;
      logic [WE:0] total;
      always_comb begin
        wide   = {1'b0, src[l*WE +: WE]};
        addend = rnd ? (({{WE{1'b0}}, 1'b1} << sh) >> 1) : '0;
        total  = wide + addend;
      end
      assign cand[k][l*NE +: NE] = NE'(total >> sh);
    end
  end

  always_comb begin
    case (lw)
      LW_16:   nar = cand[1];
      LW_32:   nar = cand[2];
      default: nar = cand[0];
    endcase
  end
endmodule

// File: rtl/nws_widen.sv
module nws_widen
  import nws_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W/2-1:0] half,
  input  lane_w_e            lw,
  input  logic [SH_W-1:0]    sh,
  input  logic               sgn,
  output logic [VEC_W-1:0]   wid
);
  localparam int HALF_W = VEC_W / 2;

  logic [NUM_LW-1:0][VEC_W-1:0] cand;

  for (genvar k = 0; k < NUM_LW; k++) begin : g_w
    localparam int NE    = 8 << k;
    localparam int WE    = 2 * NE;
    localparam int LANES = HALF_W / NE;
    for (genvar l = 0; l < LANES; l++) begin : g_l
      logic [NE-1:0] el;
      logic [WE-1:0] ext;
      always_comb begin
        el  = half[l*NE +: NE];
        ext = {{NE{sgn & el[NE-1]}}, el};
      end
      assign cand[k][l*WE +: WE] = ext << sh;
    end
  end

  always_comb begin
    case (lw)
      LW_16:   wid = cand[1];
      LW_32:   wid = cand[2];
      default: wid = cand[0];
    endcase
  end
endmodule

// File: rtl/nws_shift_unit.sv
module nws_shift_unit
  import nws_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [VEC_W-1:0]   src,
  input  logic [VEC_W/2-1:0] dst_keep,
  input  logic               half_sel,
  input  logic [3:0]         imm_hi,
  input  logic [2:0]         imm_lo,
  input  logic               op_widen,
  input  logic               is_signed,
  input  logic               round_en,
  output logic               out_valid,
  output logic [VEC_W-1:0]   result,
  output logic               err_decode,
  output logic               err_reserved
);
  localparam int HALF_W = VEC_W / 2;

  dec_t              dcd;
  logic [HALF_W-1:0] src_half;
  logic [HALF_W-1:0] nar;
  logic [VEC_W-1:0]  wid;
  logic [VEC_W-1:0]  nxt;

  nws_decode u_dec (
    .imm_hi (imm_hi),
    .imm_lo (imm_lo),
    .dcd    (dcd)
  );

  assign src_half = half_sel ? src[VEC_W-1:HALF_W] : src[HALF_W-1:0];

  nws_narrow #(.VEC_W(VEC_W)) u_nar (
    .src (src),
    .lw  (dcd.lw),
    .sh  (dcd.sh_nar),
    .rnd (round_en),
    .nar (nar)
  );

  nws_widen #(.VEC_W(VEC_W)) u_wid (
    .half (src_half),
    .lw   (dcd.lw),
    .sh   (dcd.sh_wid),
    .sgn  (is_signed),
    .wid  (wid)
  );

  always_comb begin
    if (dcd.dec_err || dcd.rsv_err) nxt = '0;
    else if (op_widen)              nxt = wid;
    else if (half_sel)              nxt = {nar, dst_keep};
    else                            nxt = {{HALF_W{1'b0}}, nar};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      err_decode   <= 1'b0;
      err_reserved <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= nxt;
        err_decode   <= dcd.dec_err;
        err_reserved <= dcd.rsv_err;
      end
    end
  end
endmodule

// File: rtl/nws_checker.sv
module nws_checker #(
  parameter int VEC_W = 128
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [VEC_W-1:0]   src,
  input logic [VEC_W/2-1:0] dst_keep,
  input logic               half_sel,
  input logic [3:0]         imm_hi,
  input logic [2:0]         imm_lo,
  input logic               op_widen,
  input logic               is_signed,
  input logic               round_en,
  input logic               out_valid,
  input logic [VEC_W-1:0]   result,
  input logic               err_decode,
  input logic               err_reserved
);
  localparam int HALF_W = VEC_W / 2;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_zero_hi_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && imm_hi == 4'd0) |=> (err_decode && !err_reserved && result == '0));

  assert_reserved_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && imm_hi[3]) |=> (err_reserved && !err_decode && result == '0));

  assert_low_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_widen && !half_sel && imm_hi != 4'd0 && !imm_hi[3])
      |=> (result[VEC_W-1:HALF_W] == '0));

  assert_keep_low_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_widen && half_sel && imm_hi != 4'd0 && !imm_hi[3])
      |=> (result[HALF_W-1:0] == $past(dst_keep)));
endmodule

bind nws_shift_unit nws_checker #(.VEC_W(VEC_W)) i_nws_checker (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .src          (src),
  .dst_keep     (dst_keep),
  .half_sel     (half_sel),
  .imm_hi       (imm_hi),
  .imm_lo       (imm_lo),
  .op_widen     (op_widen),
  .is_signed    (is_signed),
  .round_en     (round_en),
  .out_valid    (out_valid),
  .result       (result),
  .err_decode   (err_decode),
  .err_reserved (err_reserved)
);

// File: tb/test_nws_shift_unit.sv
module test_nws_shift_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] src = '0;
  logic [63:0]  dst_keep = '0;
  logic         half_sel = 1'b0;
  logic [3:0]   imm_hi = '0;
  logic [2:0]   imm_lo = '0;
  logic         op_widen = 1'b0;
  logic         is_signed = 1'b0;
  logic         round_en = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         err_decode;
  logic         err_reserved;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nws_shift_unit i_nws_shift_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .dst_keep(dst_keep),
    .half_sel(half_sel), .imm_hi(imm_hi), .imm_lo(imm_lo), .op_widen(op_widen),
    .is_signed(is_signed), .round_en(round_en), .out_valid(out_valid),
    .result(result), .err_decode(err_decode), .err_reserved(err_reserved)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_model(
    input logic [127:0] s, input logic [63:0] keep, input logic q,
    input logic [3:0] hi, input logic [2:0] lo, input logic widen,
    input logic sgn, input logic rnd,
    output logic de, output logic re, output logic [127:0] r);
    int ne, sh, imm7;
    logic [64:0] w;
    logic [63:0] nar, half, e, mk;
    logic [127:0] v, m2;
    de = (hi == 4'd0);
    re = hi[3];
    r  = '0;
    if (de || re) return;
    ne   = hi[2] ? 32 : (hi[1] ? 16 : 8);
    imm7 = int'({hi, lo});
    m2   = (128'd1 << (2*ne)) - 128'd1;
    mk   = (64'd1 << ne) - 64'd1;
    if (!widen) begin
      sh  = 2*ne - imm7;
      nar = '0;
      for (int l = 0; l < 64/ne; l++) begin
        w = 65'((s >> (l*2*ne)) & m2);
        if (rnd) w = w + (65'd1 << (sh-1));
        w = w >> sh;
        nar = nar | ((64'(w) & mk) << (l*ne));
      end
      r = q ? {nar, keep} : {64'd0, nar};
    end else begin
      sh   = imm7 - ne;
      half = q ? s[127:64] : s[63:0];
      for (int l = 0; l < 64/ne; l++) begin
        e = (half >> (l*ne)) & mk;
        if (sgn && e[ne-1]) e = e | ~mk;
        v = (128'(e) << sh) & m2;
        r = r | (v << (l*2*ne));
      end
    end
  endfunction

  task automatic run_op(input logic [127:0] s, input logic [63:0] keep, input logic q,
                        input logic [3:0] hi, input logic [2:0] lo, input logic widen,
                        input logic sgn, input logic rnd, input string tag);
    logic de, re;
    logic [127:0] exp;
    @(negedge clk);
    src = s; dst_keep = keep; half_sel = q; imm_hi = hi; imm_lo = lo;
    op_widen = widen; is_signed = sgn; round_en = rnd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ref_model(s, keep, q, hi, lo, widen, sgn, rnd, de, re, exp);
    check(out_valid == 1'b1, "R1", "out_valid", 128'(out_valid), 128'd1);
    check(err_decode == de, tag, "err_decode", 128'(err_decode), 128'(de));
    check(err_reserved == re, tag, "err_reserved", 128'(err_reserved), 128'(re));
    check(result == exp, tag, "result", result, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "reset out_valid", 128'(out_valid), 128'd0);
    check(result == '0, "R1", "reset result", result, 128'd0);
    check(!err_decode && !err_reserved, "R1", "reset flags",
          128'({err_decode, err_reserved}), 128'd0);
    rst = 1'b0;

    // R2 / R3: error encodings in both modes
    run_op({4{32'hDEAD_BEEF}}, 64'h1111, 1'b1, 4'b0000, 3'd5, 1'b0, 1'b0, 1'b1, "R2");
    run_op({4{32'hDEAD_BEEF}}, 64'h1111, 1'b0, 4'b0000, 3'd2, 1'b1, 1'b1, 1'b0, "R2");
    run_op({4{32'hCAFE_F00D}}, 64'h2222, 1'b1, 4'b1000, 3'd0, 1'b0, 1'b0, 1'b0, "R3");
    run_op({4{32'hCAFE_F00D}}, 64'h2222, 1'b0, 4'b1101, 3'd7, 1'b1, 1'b1, 1'b0, "R3");

    // R1: idle cycle holds result and drops valid
    held = result;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "idle out_valid", 128'(out_valid), 128'd0);
    check(result == held, "R1", "idle hold", result, held);

    // R5/R6: 8-bit narrow, shift 8, rounding carry out of a full lane
    run_op({8{16'hAB80}}, 64'h0, 1'b0, 4'b0001, 3'd0, 1'b0, 1'b0, 1'b0, "R5");
    run_op({8{16'hAB80}}, 64'h0, 1'b0, 4'b0001, 3'd0, 1'b0, 1'b0, 1'b1, "R6");
    run_op({8{16'hFFFF}}, 64'h0, 1'b0, 4'b0001, 3'd0, 1'b0, 1'b0, 1'b1, "R6");
    run_op({8{16'h0001}}, 64'h0, 1'b0, 4'b0001, 3'd7, 1'b0, 1'b0, 1'b1, "R6");
    // R4: 16-bit and 32-bit narrow widths
    run_op(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 64'h0, 1'b0, 4'b0010, 3'd7,
           1'b0, 1'b0, 1'b0, "R4");
    // R7 / R8: 32-bit narrow with shift 32 to each half
    run_op(128'h89AB_CDEF_0123_4567_FFFF_FFFF_8000_0000, 64'h5555_AAAA_5555_AAAA, 1'b0,
           4'b0100, 3'd0, 1'b0, 1'b0, 1'b1, "R7");
    run_op(128'h89AB_CDEF_0123_4567_FFFF_FFFF_8000_0000, 64'h5555_AAAA_5555_AAAA, 1'b1,
           4'b0100, 3'd0, 1'b0, 1'b0, 1'b0, "R8");
    // R9 / R10: widen shift zero and maximum, both halves, sign and zero extend
    run_op(128'h8000_0001_7FFF_FFFF_FFFF_FFFE_0000_0003, 64'h0, 1'b0, 4'b0100, 3'd0,
           1'b1, 1'b1, 1'b0, "R10");
    run_op(128'h8000_0001_7FFF_FFFF_FFFF_FFFE_0000_0003, 64'h0, 1'b1, 4'b0111, 3'd7,
           1'b1, 1'b0, 1'b0, "R9");
    run_op({16{8'h81}}, 64'h0, 1'b1, 4'b0001, 3'd3, 1'b1, 1'b1, 1'b0, "R10");
    run_op({16{8'h81}}, 64'h0, 1'b0, 4'b0011, 3'd1, 1'b1, 1'b0, 1'b0, "R4");
    // R11: ignored controls
    run_op({8{16'hF0F0}}, 64'h0, 1'b0, 4'b0001, 3'd4, 1'b0, 1'b1, 1'b0, "R11");
    run_op({16{8'hC3}}, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'b0001, 3'd2, 1'b1, 1'b1, 1'b1, "R11");

    for (int i = 0; i < 600; i++) begin
      logic [127:0] s;
      logic [3:0] hi;
      logic w, g, r;
      string tag;
      s  = {$urandom, $urandom, $urandom, $urandom};
      hi = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'($urandom_range(1, 7));
      w  = 1'($urandom);
      g  = 1'($urandom);
      r  = 1'($urandom);
      if (hi == 4'd0)  tag = "R2";
      else if (hi[3])  tag = "R3";
      else if (w)      tag = g ? "R10" : "R9";
      else             tag = r ? "R6" : "R5";
      run_op(s, {$urandom, $urandom}, 1'($urandom), hi, 3'($urandom), w, g, r, tag);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule